// File: doc/BRIEF.md
# I2C Eight-Port Open-Drain Expander Engine

This block is an I2C target that gives a bus controller direct access to eight open-drain I/O ports without any register pointer. It runs on the system clock and oversamples SCL and SDA. Each line passes through a two-flop synchronizer and a glitch filter. The engine then recognizes START and STOP, compares the 7-bit address and pulls SDA low for acknowledges and for read data bits of zero.

Once the address matches, the transfer direction sets the meaning of every data byte. In a write, each received byte goes straight into the port output latch. In a read, the engine returns the live port pin levels and the transition flags in turn, starting with the pins. The flags come from a separate transition-detect block. The engine drives that block with three signals: a snapshot/clear strobe during the address acknowledge, a read-in-progress level, and a STOP strobe.

A separate active-low interface reset abandons any transfer and returns the engine to idle. It leaves the port latch as it is.

Top module: `i2c_portx_engine`

## Requirements
- R1: The engine responds only to the 7-bit address whose upper three bits are 1,1,0 and whose lower four bits equal `addr_lo`. Address bits are sent MSB first, followed by the R/W bit (0 = write, 1 = read). For any other address it drives no acknowledge, emits no `snap_stb`, and ignores the rest of the transfer.
- R2: For a matching address, SDA is held low through the ninth SCL clock. `snap_stb` pulses for exactly one system clock once per matching address.
- R3: In a write, every data byte is acknowledged. At the SCL falling edge that ends its eighth bit, the byte is loaded whole into `port_o`, MSB into bit 7.
- R4: The first byte of a read is the `pin_i` value sampled during the address acknowledge, sent MSB first.
- R5: Each later read byte that the controller acknowledges alternates between `flags_i` and the live `pin_i` value. The second byte is the flags. Each byte's value is sampled on the rising SCL edge of the preceding acknowledge.
- R6: After the controller answers a read byte with NACK (SDA high on the ninth clock), the engine releases SDA. It drives nothing more until the next START or STOP.
- R7: `rd_active` goes high at the acknowledge of a matching read address. It stays high until STOP, START or interface reset. Every STOP produces a one-clock `stop_stb` pulse.
- R8: While `bus_rst_n` is low, the engine releases SDA, clears `rd_active` and returns to idle. `port_o` keeps its value, and SCL edges after the abort are ignored until a new START.
- R9: After system reset, `port_o` equals `pwr_dflt` and `sda_oe`, `rd_active`, `snap_stb` and `stop_stb` are all 0. In `port_o`, a 1 means high impedance and a 0 means drive low.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks is ignored.
- R11: A repeated START at any point restarts address reception, and no `stop_stb` is emitted for it.
- R12: SDA as driven by the engine changes only after a filtered SCL falling edge, START, STOP or interface reset, so it stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_rst_n | input | 1 | Active-low interface abort |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_lo | input | 4 | Lower four address bits |
| pwr_dflt | input | 8 | Port latch value loaded at reset |
| pin_i | input | 8 | Port pin levels |
| flags_i | input | 8 | Transition flags from the detect block |
| port_o | output | 8 | Port output latch (1 = high-Z, 0 = low) |
| snap_stb | output | 1 | Snapshot/clear strobe at address acknowledge |
| rd_active | output | 1 | Read transfer in progress |
| stop_stb | output | 1 | STOP seen |

## Verification
The assertions assume a controller that follows the bus rules. It holds SDA steady while SCL is high, except for START and STOP. Each SCL phase lasts well beyond the synchronizer-plus-filter delay, and spikes stay shorter than `FILT_CYC`. Under those conditions, every change of the engine's SDA drive or port latch follows a filtered SCL fall. The stimulus stays within these limits. Its controller uses 16-clock SCL half periods and changes SDA only in the middle of SCL low. It drops the interface reset only while SCL is low, and its only spike is a 2-clock SCL pulse against a 3-clock filter.

// File: rtl/portx_pkg.sv
package portx_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_WAIT
  } xfer_st_t;
endpackage

// File: rtl/portx_line_filter.sv
// Two-flop synchronizer followed by a persistence filter: the clean output
// follows the synchronized line only after FILT_CYC equal differing samples.
module portx_line_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      clean <= 1'b1;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 != clean) begin
        if (cnt == CW'(FILT_CYC - 1)) begin
          clean <= s2;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/portx_bus_cond.sv
// Edge and bus-condition detection on the filtered lines.
module portx_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise  = scl_f & ~scl_q;
    scl_fall  = ~scl_f & scl_q;
    start_det = scl_f & scl_q & sda_q & ~sda_f;
    stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/portx_xfer_fsm.sv
// Byte-level transfer engine: address match, write-to-latch, alternating read.
module portx_xfer_fsm
  import portx_pkg::*;
#(
  parameter logic [2:0] ADDR_HI = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_f,
  input  logic [3:0]        addr_lo,
  input  logic [BYTE_W-1:0] pwr_dflt,
  input  logic [BYTE_W-1:0] pin_i,
  input  logic [BYTE_W-1:0] flags_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] port_o,
  output logic              snap_stb,
  output logic              rd_active,
  output logic              stop_stb
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  xfer_st_t          st;
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              byte_done;
  logic              rw_q;
  logic              sel_flags;
  logic              mack;
  logic              addr_hit;

  assign addr_hit = (rx_sh[BYTE_W-1:1] == {ADDR_HI, addr_lo});

  always_ff @(posedge clk) begin
    snap_stb <= 1'b0;
    stop_stb <= 1'b0;
    if (rst) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
      rw_q      <= 1'b0;
      sel_flags <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      rd_active <= 1'b0;
      port_o    <= pwr_dflt;
    end else if (!bus_rst_n) begin
      st        <= ST_IDLE;
      sda_oe    <= 1'b0;
      rd_active <= 1'b0;
      byte_done <= 1'b0;
      bit_cnt   <= '0;
    end else if (stop_det) begin
      st        <= ST_IDLE;
      sda_oe    <= 1'b0;
      rd_active <= 1'b0;
      byte_done <= 1'b0;
      stop_stb  <= 1'b1;
    end else if (start_det) begin
      st        <= ST_ADDR;
      sda_oe    <= 1'b0;
      rd_active <= 1'b0;
      byte_done <= 1'b0;
      bit_cnt   <= '0;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            bit_cnt   <= '0;
            if (addr_hit) begin
              st        <= ST_ADDR_ACK;
              sda_oe    <= 1'b1;
              snap_stb  <= 1'b1;
              rw_q      <= rx_sh[0];
              rd_active <= rx_sh[0];
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_rise && rw_q) begin
            tx_sh     <= pin_i;
            sel_flags <= 1'b1;
          end else if (scl_fall) begin
            if (rw_q) begin
              st     <= ST_RD_DATA;
              sda_oe <= ~tx_sh[BYTE_W-1];
            end else begin
              st     <= ST_WR_DATA;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_WR_DATA: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            bit_cnt   <= '0;
            port_o    <= rx_sh;
            sda_oe    <= 1'b1;
            st        <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              st      <= ST_RD_ACK;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~tx_sh[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_f;
            if (!sda_f) begin
              tx_sh     <= sel_flags ? flags_i : pin_i;
              sel_flags <= ~sel_flags;
            end
          end else if (scl_fall) begin
            if (mack) begin
              st     <= ST_RD_DATA;
              sda_oe <= ~tx_sh[BYTE_W-1];
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_portx_engine.sv
module i2c_portx_engine
  import portx_pkg::*;
#(
  parameter int         FILT_CYC = 3,
  parameter logic [2:0] ADDR_HI  = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        addr_lo,
  input  logic [BYTE_W-1:0] pwr_dflt,
  input  logic [BYTE_W-1:0] pin_i,
  input  logic [BYTE_W-1:0] flags_i,
  output logic [BYTE_W-1:0] port_o,
  output logic              snap_stb,
  output logic              rd_active,
  output logic              stop_stb
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_l, clean_l;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_l = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    portx_line_filter #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_l[g]),
      .clean (clean_l[g])
    );
  end

  portx_bus_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (clean_l[0]),
    .sda_f     (clean_l[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  portx_xfer_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bus_rst_n (bus_rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_f     (clean_l[1]),
    .addr_lo   (addr_lo),
    .pwr_dflt  (pwr_dflt),
    .pin_i     (pin_i),
    .flags_i   (flags_i),
    .sda_oe    (sda_oe),
    .port_o    (port_o),
    .snap_stb  (snap_stb),
    .rd_active (rd_active),
    .stop_stb  (stop_stb)
  );
endmodule

// File: rtl/portx_chk.sv
module portx_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_rst_n,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic [7:0] port_o,
  input logic       snap_stb,
  input logic       stop_stb,
  input logic       rd_active
);
  p_oe_after_fall_r12: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |->
      $past(scl_fall || start_det || stop_det || !bus_rst_n));

  p_latch_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (port_o != $past(port_o)) |-> $past(scl_fall));

  p_snap_single_r2: assert property (@(posedge clk) disable iff (rst)
    snap_stb |=> !snap_stb);

  p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
    stop_stb |-> (!sda_oe && !rd_active));

  p_abort_release_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rst_n |=> (!sda_oe && !rd_active && $stable(port_o)));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({snap_stb, stop_stb}));
endmodule

bind i2c_portx_engine portx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rst_n (bus_rst_n),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .port_o    (port_o),
  .snap_stb  (snap_stb),
  .stop_stb  (stop_stb),
  .rd_active (rd_active)
);

// File: tb/sim_i2c_portx_engine.sv
`timescale 1ns/1ps
module sim_i2c_portx_engine;
  localparam int H = 16;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rst_n = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [3:0] addr_lo = 4'h5;
  logic [7:0] pwr_dflt = 8'hF0;
  logic [7:0] pin_i = 8'h00;
  logic [7:0] flags_i = 8'h00;
  logic [7:0] port_o;
  logic       snap_stb, rd_active, stop_stb;

  int n_chk = 0, n_fail = 0, snap_n = 0, stop_n = 0;
  logic [7:0] port_q[$];
  logic [7:0] port_seen;
  logic       mon_on = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_portx_engine u0 (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .addr_lo(addr_lo), .pwr_dflt(pwr_dflt), .pin_i(pin_i),
    .flags_i(flags_i), .port_o(port_o), .snap_stb(snap_stb),
    .rd_active(rd_active), .stop_stb(stop_stb)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for the port latch (R3)
  always @(negedge clk) begin
    if (snap_stb) snap_n++;
    if (stop_stb) stop_n++;
    if (mon_on && port_o !== port_seen) begin
      if (port_q.size() == 0) chk(1'b0, "R3 unexpected latch change", port_o, port_seen);
      else begin
        logic [7:0] e;
        e = port_q.pop_front();
        chk(port_o == e, "R3 latch value", port_o, e);
      end
      port_seen = port_o;
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    chk(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hp(Q);
    m_scl = 1'b1; hp(H);
    m_sda = 1'b0; hp(H);
    m_scl = 1'b0; hp(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hp(Q);
    m_scl = 1'b1; hp(H);
    m_sda = 1'b1; hp(H);
  endtask

  task automatic clk_bit(input logic b, input logic gl, output logic r, output logic stab);
    logic a;
    hp(Q);
    m_sda = b;
    if (gl) begin
      hp(2); m_scl = 1'b1; hp(2); m_scl = 1'b0; hp(2);
    end
    hp(Q);
    m_scl = 1'b1; hp(2);
    a = sda_bus; hp(H - 4);
    r = sda_bus; stab = (a == r); hp(2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic gl, output logic ack);
    logic r, s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], gl && (i == 4), r, s);
    clk_bit(1'b1, 1'b0, r, s);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic do_ack, output logic [7:0] d, output logic stab);
    logic r, s;
    stab = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, r, s);
      d[i] = r;
      stab = stab & s;
    end
    clk_bit(~do_ack, 1'b0, r, s);
  endtask

  initial begin
    logic ack, r, s;
    logic [7:0] d;
    hp(10);
    rst = 1'b0;
    hp(2);
    // R9 reset state
    chk(port_o == 8'hF0, "R9 port_o reset", port_o, 8'hF0);
    chk(sda_oe == 1'b0, "R9 sda_oe reset", sda_oe, 0);
    chk(rd_active == 1'b0 && snap_stb == 1'b0 && stop_stb == 1'b0, "R9 strobes reset",
        {rd_active, snap_stb, stop_stb}, 0);
    port_seen = port_o;
    mon_on = 1'b1;

    // R2/R3 write two bytes to address 0x65
    bus_start();
    send_byte(8'hCA, 1'b0, ack);
    chk(ack, "R2 address ack", ack, 1);
    port_q.push_back(8'h3C);
    send_byte(8'h3C, 1'b0, ack);
    chk(ack, "R3 data ack", ack, 1);
    port_q.push_back(8'hA5);
    send_byte(8'hA5, 1'b0, ack);
    bus_stop();
    chk(snap_n == 1, "R2 one snapshot", snap_n, 1);
    chk(stop_n == 1, "R7 stop strobe", stop_n, 1);
    chk(port_o == 8'hA5, "R3 latch after write", port_o, 8'hA5);

    // R1 wrong address 0x64
    bus_start();
    send_byte(8'hC8, 1'b0, ack);
    chk(!ack, "R1 no ack for other address", ack, 0);
    send_byte(8'h00, 1'b0, ack);
    bus_stop();
    chk(snap_n == 1, "R1 no snapshot", snap_n, 1);
    chk(port_o == 8'hA5, "R1 latch untouched", port_o, 8'hA5);

    // R4/R5/R6/R7 read alternating
    pin_i = 8'h5A; flags_i = 8'hC3;
    bus_start();
    send_byte(8'hCB, 1'b0, ack);
    chk(ack, "R2 read address ack", ack, 1);
    chk(rd_active, "R7 rd_active in read", rd_active, 1);
    recv_byte(1'b1, d, s);
    chk(d == 8'h5A, "R4 first byte pins", d, 8'h5A);
    chk(s, "R12 SDA stable while SCL high", s, 1);
    pin_i = 8'h0F;
    recv_byte(1'b1, d, s);
    chk(d == 8'hC3, "R5 second byte flags", d, 8'hC3);
    recv_byte(1'b1, d, s);
    chk(d == 8'h0F, "R5 third byte live pins", d, 8'h0F);
    recv_byte(1'b0, d, s);
    chk(d == 8'hC3, "R5 fourth byte flags", d, 8'hC3);
    clk_bit(1'b1, 1'b0, r, s);
    chk(r == 1'b1 && sda_oe == 1'b0, "R6 released after NACK", r, 1);
    chk(rd_active, "R7 rd_active held to STOP", rd_active, 1);
    bus_stop();
    chk(!rd_active, "R7 rd_active cleared by STOP", rd_active, 0);
    chk(stop_n == 3, "R7 stop count", stop_n, 3);

    // R11 repeated START
    bus_start();
    send_byte(8'hCA, 1'b0, ack);
    bus_start();
    chk(stop_n == 3, "R11 no stop strobe on repeated START", stop_n, 3);
    send_byte(8'hCB, 1'b0, ack);
    chk(ack && rd_active, "R11 readdressed as read", {ack, rd_active}, 3);
    recv_byte(1'b0, d, s);
    chk(d == 8'h0F, "R11 read after repeated START", d, 8'h0F);
    bus_stop();
    chk(snap_n == 4, "R2 snapshot count", snap_n, 4);

    // R10 glitch on SCL inside a write byte
    bus_start();
    send_byte(8'hCA, 1'b0, ack);
    port_q.push_back(8'h96);
    send_byte(8'h96, 1'b1, ack);
    chk(ack, "R10 byte acked despite spike", ack, 1);
    bus_stop();
    chk(port_o == 8'h96, "R10 spike ignored", port_o, 8'h96);

    // R8 abort during write
    bus_start();
    send_byte(8'hCA, 1'b0, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, r, s);
    hp(4); bus_rst_n = 1'b0; hp(4); bus_rst_n = 1'b1;
    for (int i = 0; i < 4; i++) clk_bit(1'b1, 1'b0, r, s);
    clk_bit(1'b1, 1'b0, r, s);
    chk(r == 1'b1, "R8 no ack after abort", r, 1);
    bus_stop();
    chk(port_o == 8'h96, "R8 latch kept on abort", port_o, 8'h96);

    // R8 abort during read while driving low
    pin_i = 8'h00;
    bus_start();
    send_byte(8'hCB, 1'b0, ack);
    clk_bit(1'b1, 1'b0, r, s);
    chk(r == 1'b0, "R4 slave drives zero bit", r, 0);
    hp(Q);
    chk(sda_oe == 1'b1, "R4 next zero bit driven", sda_oe, 1);
    bus_rst_n = 1'b0; hp(2);
    chk(sda_oe == 1'b0 && rd_active == 1'b0, "R8 read abort releases", {sda_oe, rd_active}, 0);
    bus_rst_n = 1'b1;
    bus_stop();

    hp(10);
    chk(port_q.size() == 0, "R3 all writes seen", port_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule